// File: doc/BRIEF.md
# SPI Transmit/Receive Queue Buffer

This block sits between a host register interface and an SPI shift engine. The host writes transmit entries through a push port. Each entry pairs a per-frame command word with a data word. Received frames come back to the host through a pop port. The shift engine takes the oldest transmit entry on request and hands each received frame to the receive queue.

Both queues are four entries deep by default. Each queue has its own bypass control. A bypassed queue acts as a one-entry double buffer, and its count, request flag and error flag keep their one-entry meaning. The bypass controls must be set while the block is held in reset, before the first access. Changing them later is not supported.

The status outputs are:
- the fill level of each queue;
- a transmit fill request, high while the transmit queue has a free slot;
- a receive drain request, high while the receive queue holds data;
- two sticky error flags, transmit underflow and receive overflow, each cleared by a write-one-to-clear pulse.

Each queue also has a flush input that empties it in one cycle.

Top module: `spi_cmd_fifo_buf`

## Requirements
- R1: With bypass off, the transmit queue holds up to DEPTH (default 4) entries of {command, data}. Entries come out oldest first, with command and data kept together. A push while the queue is full is discarded and does not change the count or the contents.
- R2: The transmit count rises by one in the cycle after an accepted push. It falls by one in the cycle after the engine loads an entry, which happens when `eng_tx_req` is high and the queue is not empty. If both happen in the same cycle, the count is unchanged.
- R3: `tx_fill_req` is high exactly when the transmit count is below the capacity. The capacity is DEPTH, or 1 when bypassed.
- R4: `tx_underflow` becomes 1 in the cycle after `eng_tx_req` is high while the transmit queue is empty. It stays 1 until a `clr_underflow` pulse. If a set and a clear arrive in the same cycle, the set wins.
- R5: The receive queue stores frames from `eng_rx_valid` oldest first. `host_pop_data` shows the oldest frame. A `host_pop` pulse removes that frame and lowers `rx_count` by one. `rx_drain_req` is high exactly when `rx_count` is nonzero.
- R6: A frame that arrives while the receive queue is full is discarded, and `rx_overflow` becomes 1 in the next cycle. The stored frames are not changed. A `clr_overflow` pulse clears the flag.
- R7: With `cfg_tx_bypass` = 1, the transmit queue holds one entry. After one push the count is 1 and `tx_fill_req` is 0. A second push is discarded.
- R8: With `cfg_rx_bypass` = 1, the receive queue holds one frame. A second frame before a pop is discarded and sets `rx_overflow`. The first frame is kept.
- R9: The two bypass controls are independent. A bypassed transmit queue leaves the receive queue at full depth, and a bypassed receive queue leaves the transmit queue at full depth.
- R10: A `tx_flush` or `rx_flush` pulse sets the count of that queue to 0 in the next cycle. A push in the same cycle as a flush is discarded. The next accepted push becomes the new head.
- R11: `host_pop` while the receive queue is empty, or `eng_tx_req` while the transmit queue is empty, leaves that count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tx_bypass | input | 1 | Transmit queue acts as a one-entry buffer |
| cfg_rx_bypass | input | 1 | Receive queue acts as a one-entry buffer |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_flush | input | 1 | Empty the receive queue |
| host_push | input | 1 | Push one transmit entry |
| host_push_cmd | input | CMD_W | Command word of the pushed entry |
| host_push_data | input | DATA_W | Data word of the pushed entry |
| host_pop | input | 1 | Remove the oldest received frame |
| host_pop_data | output | DATA_W | Oldest received frame |
| eng_tx_req | input | 1 | Engine loads the head transmit entry |
| eng_tx_valid | output | 1 | Transmit head entry is valid |
| eng_tx_cmd | output | CMD_W | Command word of the head entry |
| eng_tx_data | output | DATA_W | Data word of the head entry |
| eng_rx_valid | input | 1 | A received frame is presented |
| eng_rx_data | input | DATA_W | Received frame |
| clr_underflow | input | 1 | Write-one-to-clear for `tx_underflow` |
| clr_overflow | input | 1 | Write-one-to-clear for `rx_overflow` |
| tx_count | output | CNT_W | Valid transmit entries |
| rx_count | output | CNT_W | Valid receive frames |
| tx_fill_req | output | 1 | Transmit queue has a free slot |
| rx_drain_req | output | 1 | Receive queue holds data |
| tx_underflow | output | 1 | Sticky transmit underflow flag |
| rx_overflow | output | 1 | Sticky receive overflow flag |

## Verification
The bench pushes into a full transmit queue and then checks that the discarded word never surfaces. A design that overwrote the head or let the write pointer wrap would show that word later.

A push and a load land in the same cycle. A design that handled this wrongly would double-count or lose the entry.

In bypass mode the bench checks that the count stops at one and that the request flags follow. A design that kept the full capacity would accept a second entry.

A flush is combined with a push, and an error flag's set is combined with its clear. Here the wrong priority would leave stale data behind, or would drop an underflow event.

// File: rtl/spi_qbuf_pkg.sv
package spi_qbuf_pkg;

    // Pointer width for a queue of n slots (at least one bit).
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Queue operation performed in one cycle: {pop, push}.
    typedef enum logic [1:0] {
        Q_IDLE = 2'b00,
        Q_PUSH = 2'b01,
        Q_POP  = 2'b10,
        Q_BOTH = 2'b11
    } q_op_e;

endpackage

// File: rtl/qbuf_sticky.sv
module qbuf_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;   // an event never gets lost to a clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(flag));
endmodule

// File: rtl/qbuf_fifo.sv
module qbuf_fifo
    import spi_qbuf_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = idx_bits(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];

    logic [CNT_W-1:0] cap;
    logic [PTR_W-1:0] last_idx;
    logic             do_push, do_pop;
    q_op_e            op;

    // Capacity collapses to one slot in bypass mode.
    assign cap      = bypass ? CNT_W'(1) : CNT_W'(DEPTH);
    assign last_idx = bypass ? '0 : PTR_W'(DEPTH - 1);
    assign full     = (st_q.cnt >= cap);
    assign empty    = (st_q.cnt == '0);
    assign do_push  = push && !full  && !flush;
    assign do_pop   = pop  && !empty && !flush;
    assign op       = q_op_e'({do_pop, do_push});

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p,
                                             input logic [PTR_W-1:0] lim);
        return (p == lim) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            unique case (op)
                Q_PUSH: begin
                    st_d.wr  = adv(st_q.wr, last_idx);
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
                Q_POP: begin
                    st_d.rd  = adv(st_q.rd, last_idx);
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
                Q_BOTH: begin
                    st_d.wr = adv(st_q.wr, last_idx);
                    st_d.rd = adv(st_q.rd, last_idx);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= wdata;
    end

    assign rdata = mem_q[st_q.rd];
    assign count = st_q.cnt;

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop && !flush) |=> count == $past(count) + CNT_W'(1));
    p_pop_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push && !flush) |=> count == $past(count) - CNT_W'(1));
    p_full_push_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(count));
    p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);
    p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> count == '0);
    p_bypass_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> count <= CNT_W'(1));
endmodule

// File: rtl/spi_cmd_fifo_buf.sv
module spi_cmd_fifo_buf
    import spi_qbuf_pkg::*;
#(
    parameter int unsigned CMD_W  = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tx_bypass,
    input  logic              cfg_rx_bypass,
    input  logic              tx_flush,
    input  logic              rx_flush,
    input  logic              host_push,
    input  logic [CMD_W-1:0]  host_push_cmd,
    input  logic [DATA_W-1:0] host_push_data,
    input  logic              host_pop,
    output logic [DATA_W-1:0] host_pop_data,
    input  logic              eng_tx_req,
    output logic              eng_tx_valid,
    output logic [CMD_W-1:0]  eng_tx_cmd,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_rx_valid,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              clr_underflow,
    input  logic              clr_overflow,
    output logic [CNT_W-1:0]  tx_count,
    output logic [CNT_W-1:0]  rx_count,
    output logic              tx_fill_req,
    output logic              rx_drain_req,
    output logic              tx_underflow,
    output logic              rx_overflow
);
    localparam int unsigned TXE_W = CMD_W + DATA_W;

    logic [TXE_W-1:0] tx_head;
    logic             tx_full, tx_empty, rx_full, rx_empty;

    qbuf_fifo #(.WIDTH(TXE_W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .bypass(cfg_tx_bypass),
        .flush (tx_flush),
        .push  (host_push),
        .wdata ({host_push_cmd, host_push_data}),
        .pop   (eng_tx_req),
        .rdata (tx_head),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    qbuf_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .bypass(cfg_rx_bypass),
        .flush (rx_flush),
        .push  (eng_rx_valid),
        .wdata (eng_rx_data),
        .pop   (host_pop),
        .rdata (host_pop_data),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    qbuf_sticky u_udf (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (eng_tx_req && tx_empty),
        .clr  (clr_underflow),
        .flag (tx_underflow)
    );

    qbuf_sticky u_ovf (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (eng_rx_valid && rx_full && !rx_flush),
        .clr  (clr_overflow),
        .flag (rx_overflow)
    );

    assign eng_tx_cmd   = tx_head[TXE_W-1:DATA_W];
    assign eng_tx_data  = tx_head[DATA_W-1:0];
    assign eng_tx_valid = !tx_empty;
    assign tx_fill_req  = !tx_full;
    assign rx_drain_req = !rx_empty;

    p_fill_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fill_req == (tx_count < (cfg_tx_bypass ? CNT_W'(1) : CNT_W'(DEPTH))));
    p_drain_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drain_req == (rx_count != '0));
    p_underflow_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_req && tx_count == '0) |=> tx_underflow);
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_valid && !rx_flush && !host_pop &&
         rx_count == (cfg_rx_bypass ? CNT_W'(1) : CNT_W'(DEPTH))) |=> rx_overflow && $stable(rx_count));
    p_rx_bypass_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rx_bypass |-> rx_count <= CNT_W'(1));
endmodule

// File: tb/spi_cmd_fifo_buf_bench.sv
module spi_cmd_fifo_buf_bench;
    localparam int CW = 4;
    localparam int DW = 8;
    localparam int DP = 4;
    localparam int NW = $clog2(DP + 1);

    logic clk = 1'b0;
    logic rst_n, cfg_tx_bypass, cfg_rx_bypass, tx_flush, rx_flush;
    logic host_push, host_pop, eng_tx_req, eng_rx_valid, clr_underflow, clr_overflow;
    logic [CW-1:0] host_push_cmd, eng_tx_cmd;
    logic [DW-1:0] host_push_data, host_pop_data, eng_tx_data, eng_rx_data;
    logic eng_tx_valid, tx_fill_req, rx_drain_req, tx_underflow, rx_overflow;
    logic [NW-1:0] tx_count, rx_count;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;  // 125 MHz

    spi_cmd_fifo_buf #(.CMD_W(CW), .DATA_W(DW), .DEPTH(DP)) u_spi_cmd_fifo_buf (
        .clk(clk), .rst_n(rst_n), .cfg_tx_bypass(cfg_tx_bypass), .cfg_rx_bypass(cfg_rx_bypass),
        .tx_flush(tx_flush), .rx_flush(rx_flush), .host_push(host_push),
        .host_push_cmd(host_push_cmd), .host_push_data(host_push_data),
        .host_pop(host_pop), .host_pop_data(host_pop_data), .eng_tx_req(eng_tx_req),
        .eng_tx_valid(eng_tx_valid), .eng_tx_cmd(eng_tx_cmd), .eng_tx_data(eng_tx_data),
        .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
        .clr_underflow(clr_underflow), .clr_overflow(clr_overflow),
        .tx_count(tx_count), .rx_count(rx_count), .tx_fill_req(tx_fill_req),
        .rx_drain_req(rx_drain_req), .tx_underflow(tx_underflow), .rx_overflow(rx_overflow)
    );

    // Vector: {push, load, data[7:0], expected count[2:0], expected head data[7:0]}
    localparam logic [20:0] TXV [10] = '{
        {1'b1, 1'b0, 8'h11, 3'd1, 8'h11},
        {1'b1, 1'b0, 8'h22, 3'd2, 8'h11},
        {1'b1, 1'b0, 8'h33, 3'd3, 8'h11},
        {1'b1, 1'b0, 8'h44, 3'd4, 8'h11},
        {1'b1, 1'b0, 8'h55, 3'd4, 8'h11},
        {1'b0, 1'b1, 8'h00, 3'd3, 8'h22},
        {1'b1, 1'b1, 8'h66, 3'd3, 8'h33},
        {1'b0, 1'b1, 8'h00, 3'd2, 8'h44},
        {1'b0, 1'b1, 8'h00, 3'd1, 8'h66},
        {1'b0, 1'b1, 8'h00, 3'd0, 8'h00}
    };

    function automatic logic [CW-1:0] cmd_of(input logic [DW-1:0] d);
        return d[CW-1:0] ^ 4'hA;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic idle_inputs();
        tx_flush = 0; rx_flush = 0; host_push = 0; host_pop = 0;
        eng_tx_req = 0; eng_rx_valid = 0; clr_underflow = 0; clr_overflow = 0;
        host_push_cmd = '0; host_push_data = '0; eng_rx_data = '0;
    endtask

    task automatic do_reset(input bit txb, input bit rxb);
        @(negedge clk);
        rst_n = 0; cfg_tx_bypass = txb; cfg_rx_bypass = rxb;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic push_tx(input logic [DW-1:0] d);
        host_push = 1; host_push_data = d; host_push_cmd = cmd_of(d);
        @(negedge clk);
        host_push = 0;
    endtask

    task automatic send_rx(input logic [DW-1:0] d);
        eng_rx_valid = 1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_valid = 0;
    endtask

    task automatic pop_rx();
        host_pop = 1;
        @(negedge clk);
        host_pop = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 0; cfg_tx_bypass = 0; cfg_rx_bypass = 0;
        idle_inputs();
        do_reset(0, 0);

        // Reset state
        chk(tx_count == 0 && rx_count == 0, "reset counts R2 R5", int'(tx_count), 0);
        chk(tx_fill_req && !rx_drain_req, "reset requests R3 R5", int'({tx_fill_req, rx_drain_req}), 2);
        chk(!tx_underflow && !rx_overflow, "reset flags R4 R6", int'({tx_underflow, rx_overflow}), 0);

        // Table-driven transmit sequence
        for (int i = 0; i < 10; i++) begin
            host_push = TXV[i][20]; eng_tx_req = TXV[i][19];
            host_push_data = TXV[i][18:11]; host_push_cmd = cmd_of(TXV[i][18:11]);
            @(negedge clk);
            host_push = 0; eng_tx_req = 0;
            chk(tx_count == TXV[i][10:8], $sformatf("tx count step %0d R2", i), int'(tx_count), int'(TXV[i][10:8]));
            chk(tx_fill_req == (TXV[i][10:8] < 3'd4), $sformatf("fill req step %0d R3", i),
                int'(tx_fill_req), int'(TXV[i][10:8] < 3'd4));
            if (TXV[i][10:8] != 0) begin
                chk(eng_tx_data == TXV[i][7:0], $sformatf("head data step %0d R1", i),
                    int'(eng_tx_data), int'(TXV[i][7:0]));
                chk(eng_tx_cmd == cmd_of(TXV[i][7:0]), $sformatf("head cmd step %0d R1", i),
                    int'(eng_tx_cmd), int'(cmd_of(TXV[i][7:0])));
            end
        end
        chk(!tx_underflow, "no underflow yet R4", int'(tx_underflow), 0);

        // Underflow on empty load
        eng_tx_req = 1; @(negedge clk); eng_tx_req = 0;
        chk(tx_underflow == 1, "underflow set R4", int'(tx_underflow), 1);
        chk(tx_count == 0, "empty load keeps count R11", int'(tx_count), 0);
        @(negedge clk);
        chk(tx_underflow == 1, "underflow sticky R4", int'(tx_underflow), 1);
        clr_underflow = 1; @(negedge clk); clr_underflow = 0;
        chk(tx_underflow == 0, "underflow cleared R4", int'(tx_underflow), 0);
        clr_underflow = 1; eng_tx_req = 1; @(negedge clk); clr_underflow = 0; eng_tx_req = 0;
        chk(tx_underflow == 1, "set beats clear R4", int'(tx_underflow), 1);

        // Receive queue
        send_rx(8'hA1); send_rx(8'hA2); send_rx(8'hA3); send_rx(8'hA4);
        chk(rx_count == 4 && rx_drain_req, "rx full count R5", int'(rx_count), 4);
        chk(host_pop_data == 8'hA1, "rx oldest R5", int'(host_pop_data), 'hA1);
        send_rx(8'hB5);
        chk(rx_overflow == 1, "overflow set R6", int'(rx_overflow), 1);
        chk(rx_count == 4, "overflow count held R6", int'(rx_count), 4);
        pop_rx();
        chk(rx_count == 3 && host_pop_data == 8'hA2, "pop advances R5", int'(host_pop_data), 'hA2);
        pop_rx(); pop_rx();
        chk(host_pop_data == 8'hA4, "dropped frame absent R6", int'(host_pop_data), 'hA4);
        pop_rx();
        chk(rx_count == 0 && !rx_drain_req, "rx drained R5", int'(rx_count), 0);
        pop_rx();
        chk(rx_count == 0, "pop on empty R11", int'(rx_count), 0);
        clr_overflow = 1; @(negedge clk); clr_overflow = 0;
        chk(rx_overflow == 0, "overflow cleared R6", int'(rx_overflow), 0);

        // Flush
        push_tx(8'h71); push_tx(8'h72);
        tx_flush = 1; host_push = 1; host_push_data = 8'h73; host_push_cmd = cmd_of(8'h73);
        @(negedge clk); tx_flush = 0; host_push = 0;
        chk(tx_count == 0, "tx flush empties R10", int'(tx_count), 0);
        push_tx(8'h74);
        chk(tx_count == 1 && eng_tx_data == 8'h74, "new head after flush R10", int'(eng_tx_data), 'h74);
        send_rx(8'hC1); send_rx(8'hC2);
        rx_flush = 1; @(negedge clk); rx_flush = 0;
        chk(rx_count == 0 && !rx_drain_req, "rx flush empties R10", int'(rx_count), 0);

        // Transmit bypass, receive at full depth
        do_reset(1, 0);
        chk(tx_fill_req == 1, "bypass empty fill req R7", int'(tx_fill_req), 1);
        push_tx(8'h81);
        chk(tx_count == 1 && tx_fill_req == 0, "bypass one entry R7", int'(tx_count), 1);
        push_tx(8'h82);
        chk(tx_count == 1 && eng_tx_data == 8'h81, "bypass second push dropped R7", int'(eng_tx_data), 'h81);
        eng_tx_req = 1; @(negedge clk); eng_tx_req = 0;
        chk(tx_count == 0 && tx_fill_req == 1 && !tx_underflow, "bypass load R7", int'(tx_count), 0);
        push_tx(8'h83);
        chk(eng_tx_data == 8'h83 && eng_tx_cmd == cmd_of(8'h83), "bypass reuse slot R7", int'(eng_tx_data), 'h83);
        send_rx(8'hD1); send_rx(8'hD2); send_rx(8'hD3); send_rx(8'hD4);
        chk(rx_count == 4 && !rx_overflow, "rx full depth with tx bypass R9", int'(rx_count), 4);

        // Receive bypass, transmit at full depth
        do_reset(0, 1);
        send_rx(8'hE1);
        chk(rx_count == 1 && rx_drain_req, "rx bypass one frame R8", int'(rx_count), 1);
        send_rx(8'hE2);
        chk(rx_overflow == 1 && rx_count == 1, "rx bypass overflow R8", int'(rx_overflow), 1);
        chk(host_pop_data == 8'hE1, "rx bypass keeps first R8", int'(host_pop_data), 'hE1);
        pop_rx();
        send_rx(8'hE3);
        chk(host_pop_data == 8'hE3 && rx_count == 1, "rx bypass refill R8", int'(host_pop_data), 'hE3);
        push_tx(8'h91); push_tx(8'h92); push_tx(8'h93); push_tx(8'h94);
        chk(tx_count == 4 && tx_fill_req == 0, "tx full depth with rx bypass R9", int'(tx_count), 4);

        summary();
    end
endmodule